// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block derives CAN bit timing from the system clock. A prescaler divides the clock into time quanta. Each bit is built from a one-quantum synchronization segment, a programmable segment ahead of the sample point and a programmable segment after it. At the sample point the block takes the receive level, after an optional inversion. It can take one sample or a majority vote of three samples. A falling (recessive-to-dominant) edge on the line moves the bit boundary to follow a remote transmitter. The size of that move is capped by a programmable jump width.

A 16-bit timing word holds all timing settings. A hold flag gates every write to that word and to the polarity control. The hold flag is set by hardware reset or by a bus-off indication, and software clears it to start bit timing. While the hold flag is set, the block produces no strobes and its counters stay at zero. A frame decoder downstream uses the sample strobe, the sampled bit and the bit-start strobe.

Top module: `cbt_top`

## Requirements
- R1: After hardware reset the hold flag reads 1, the timing word reads 0000h, the inversion flag reads 0, and neither strobe pulses.
- R2: The timing word takes a write only while the hold flag is 1. With the hold flag at 0 a write leaves both the readback and the bit timing unchanged. Field layout: bits 5:0 prescale P, bits 7:6 jump J, bits 11:8 pre-sample length A, bits 14:12 post-sample length B, bit 15 vote enable.
- R3: One quantum lasts P+1 clocks. With no line edges, consecutive bit-start strobes are (P+1)·(A+B+3) clocks apart.
- R4: The sync segment is one quantum. The sample strobe comes (P+1)·(A+2) clocks after a bit-start strobe, and the two strobes never pulse in the same cycle.
- R5: The sampled level is the line XOR the inversion flag. The inversion flag is written through the mode port only while the hold flag is 1.
- R6: With vote enable 0, the sampled bit is the single line value at the sample point. With vote enable 1, it is the majority of the values at the last three quantum boundaries up to and including the sample point.
- R7: A falling edge in quantum k (from 0) of the pre-sample segment lengthens that segment by min(k+1, J+1) quanta.
- R8: A falling edge in quantum k of the post-sample segment sets that segment's length to max((B+1) − min(B+1−k, J+1), k+1) quanta.
- R9: Only the first falling edge in a bit resynchronizes. Edges in the sync segment and rising edges change nothing.
- R10: An asserted bus-off input sets the hold flag. While the hold flag is set no strobe pulses. After the flag is cleared, the first bit-start strobe comes one full bit period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_wdata | input | 16 | Timing word write data |
| mode_we | input | 1 | Mode write strobe (hold flag and inversion flag) |
| mode_hold_d | input | 1 | New hold flag value |
| mode_rxinv_d | input | 1 | New inversion flag value |
| bus_off | input | 1 | Bus-off indication, forces the hold flag |
| rx_raw | input | 1 | Raw receive line, 1 = recessive |
| timing_q | output | 16 | Timing word readback |
| hold_q | output | 1 | Hold flag readback |
| rxinv_q | output | 1 | Inversion flag readback |
| rx_bit | output | 1 | Sampled bit value |
| sample_stb | output | 1 | One-cycle pulse when rx_bit is updated |
| bit_start_stb | output | 1 | One-cycle pulse at the start of each bit |

## Verification
The bench elaborates the block with its default field widths (6-bit prescale, 2-bit jump, 4-bit and 3-bit segment lengths, three-sample vote), which give the 16-bit word above. At run time it mostly uses a two-clock quantum with pre/post lengths of 6 and 4 quanta and a jump of 2. The quantum-level timing is then fine enough to place an edge in the middle of any chosen quantum. That covers jump clipping on both sides of the sample point, the clamp in the last post-sample quantum, and a one-quantum glitch that only the vote rejects. A second word with a four-clock quantum and a zero jump checks the period formula at another prescale.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int QLEN_W = 8;
  typedef logic [QLEN_W-1:0] qlen_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PRE  = 2'd1,
    SEG_POST = 2'd2
  } seg_e;

  // Programmed field value to quanta.
  function automatic qlen_t field_len(input qlen_t f);
    return f + qlen_t'(1);
  endfunction

  // Extra quanta for an edge in pre-sample quantum cnt.
  function automatic qlen_t pre_stretch(input qlen_t cnt, input qlen_t jw);
    qlen_t err;
    err = cnt + qlen_t'(1);
    return (err < jw) ? err : jw;
  endfunction

  // New post-sample length for an edge in post-sample quantum cnt.
  function automatic qlen_t post_len(input qlen_t len, input qlen_t cnt, input qlen_t jw);
    qlen_t err;
    qlen_t cut;
    qlen_t nl;
    err = len - cnt;
    cut = (err < jw) ? err : jw;
    nl  = len - cut;
    return (nl < cnt + qlen_t'(1)) ? cnt + qlen_t'(1) : nl;
  endfunction
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             mode_we,
  input  logic             mode_hold_d,
  input  logic             mode_rxinv_d,
  input  logic             bus_off,
  output logic [CFG_W-1:0] timing_q,
  output logic             hold_q,
  output logic             rxinv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= '0;
      hold_q   <= 1'b1;
      rxinv_q  <= 1'b0;
    end else begin
      if (cfg_we && hold_q)  timing_q <= cfg_wdata;
      if (mode_we && hold_q) rxinv_q  <= mode_rxinv_d;
      if (bus_off)           hold_q   <= 1'b1;
      else if (mode_we)      hold_q   <= mode_hold_d;
    end
  end

  AST_TIMING_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |=> $stable(timing_q)); // R2
  AST_RXINV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |=> $stable(rxinv_q)); // R5
  AST_BUSOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |=> hold_q); // R10
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int PSC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] pscl,
  output logic             tq_tick
);
  localparam logic [PSC_W-1:0] ONE = 1;
  logic [PSC_W-1:0] pc_q;

  assign tq_tick = run && (pc_q == pscl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pc_q <= '0;
    else if (!run || tq_tick)  pc_q <= '0;
    else                       pc_q <= pc_q + ONE;
  end

  AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pc_q <= pscl); // R3
  AST_PC_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pc_q == '0); // R10
endmodule

// File: rtl/cbt_bit_fsm.sv
module cbt_bit_fsm
  import cbt_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int POST_W = 3,
  parameter int JMP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tq_tick,
  input  logic [PRE_W-1:0]  pre_f,
  input  logic [POST_W-1:0] post_f,
  input  logic [JMP_W-1:0]  jmp_f,
  input  logic              fall_edge,
  output logic              sample_pt,
  output logic              bit_end
);
  qlen_t len_pre, len_post, jw;
  seg_e  seg_q;
  qlen_t cnt_q, len_q, len_adj;
  logic  rs_done_q, rs_hit, last;

  assign len_pre  = field_len(qlen_t'(pre_f));
  assign len_post = field_len(qlen_t'(post_f));
  assign jw       = field_len(qlen_t'(jmp_f));

  always_comb begin
    len_adj = len_q;
    rs_hit  = 1'b0;
    if (fall_edge && !rs_done_q) begin
      if (seg_q == SEG_PRE) begin
        len_adj = len_q + pre_stretch(cnt_q, jw);
        rs_hit  = 1'b1;
      end else if (seg_q == SEG_POST) begin
        len_adj = post_len(len_q, cnt_q, jw);
        rs_hit  = 1'b1;
      end
    end
  end

  assign last      = (cnt_q + qlen_t'(1)) == len_adj;
  assign sample_pt = tq_tick && (seg_q == SEG_PRE)  && last;
  assign bit_end   = tq_tick && (seg_q == SEG_POST) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q     <= SEG_SYNC;
      cnt_q     <= '0;
      len_q     <= qlen_t'(1);
      rs_done_q <= 1'b0;
    end else if (!run) begin
      seg_q     <= SEG_SYNC;
      cnt_q     <= '0;
      len_q     <= qlen_t'(1);
      rs_done_q <= 1'b0;
    end else begin
      len_q <= len_adj;
      if (rs_hit) rs_done_q <= 1'b1;
      if (tq_tick) begin
        if (last) begin
          cnt_q <= '0;
          case (seg_q)
            SEG_SYNC: begin
              seg_q <= SEG_PRE;
              len_q <= len_pre;
            end
            SEG_PRE: begin
              seg_q <= SEG_POST;
              len_q <= len_post;
            end
            default: begin
              seg_q     <= SEG_SYNC;
              len_q     <= qlen_t'(1);
              rs_done_q <= 1'b0;
            end
          endcase
        end else begin
          cnt_q <= cnt_q + qlen_t'(1);
        end
      end
    end
  end

  AST_SYNC_SINGLE_TQ: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q == SEG_SYNC |-> (cnt_q == '0 && len_q == qlen_t'(1))); // R4
  AST_PRE_STRETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q == SEG_PRE |-> (len_q >= len_pre && len_q <= len_pre + jw)); // R7
  AST_POST_SHRINK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q == SEG_POST |-> (len_q <= len_post && len_q + jw >= len_post && cnt_q < len_q)); // R8
  AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rs_done_q && !tq_tick) |=> $stable(len_q)); // R9
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler #(
  parameter int NSAMP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tq_tick,
  input  logic rxp,
  input  logic vote_en,
  input  logic sample_pt,
  output logic rx_bit
);
  logic [NSAMP-1:0] win_q, win_d;
  logic             maj;

  assign win_d = {win_q[NSAMP-2:0], rxp};
  assign maj   = $countones(win_d) > (NSAMP / 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '1;
      rx_bit <= 1'b1;
    end else begin
      if (!run)         win_q <= '1;
      else if (tq_tick) win_q <= win_d;
      if (sample_pt)    rx_bit <= vote_en ? maj : rxp;
    end
  end

  AST_SINGLE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && !vote_en) |=> rx_bit == $past(rxp)); // R6
  AST_VOTE_UNANIMOUS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && vote_en && (&win_d)) |=> rx_bit); // R6
endmodule

// File: rtl/cbt_top.sv
module cbt_top
  import cbt_pkg::*;
#(
  parameter int PSC_W  = 6,
  parameter int JMP_W  = 2,
  parameter int PRE_W  = 4,
  parameter int POST_W = 3,
  parameter int NSAMP  = 3,
  localparam int CFG_W = PSC_W + JMP_W + PRE_W + POST_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             mode_we,
  input  logic             mode_hold_d,
  input  logic             mode_rxinv_d,
  input  logic             bus_off,
  input  logic             rx_raw,
  output logic [CFG_W-1:0] timing_q,
  output logic             hold_q,
  output logic             rxinv_q,
  output logic             rx_bit,
  output logic             sample_stb,
  output logic             bit_start_stb
);
  localparam int JMP_LO  = PSC_W;
  localparam int PRE_LO  = JMP_LO + JMP_W;
  localparam int POST_LO = PRE_LO + PRE_W;
  localparam int VOTE_B  = POST_LO + POST_W;

  logic run, rxp, rxp_q, fall_edge, tq_tick, sample_pt, bit_end;

  cbt_cfg_regs #(.CFG_W(CFG_W)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .mode_we, .mode_hold_d,
    .mode_rxinv_d, .bus_off, .timing_q, .hold_q, .rxinv_q
  );

  assign run       = !hold_q;
  assign rxp       = rx_raw ^ rxinv_q;
  assign fall_edge = run && rxp_q && !rxp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxp_q         <= 1'b1;
      sample_stb    <= 1'b0;
      bit_start_stb <= 1'b0;
    end else begin
      rxp_q         <= rxp;
      sample_stb    <= sample_pt;
      bit_start_stb <= bit_end;
    end
  end

  cbt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk, .rst_n, .run, .pscl(timing_q[PSC_W-1:0]), .tq_tick
  );

  cbt_bit_fsm #(.PRE_W(PRE_W), .POST_W(POST_W), .JMP_W(JMP_W)) u_fsm (
    .clk, .rst_n, .run, .tq_tick,
    .pre_f(timing_q[PRE_LO +: PRE_W]),
    .post_f(timing_q[POST_LO +: POST_W]),
    .jmp_f(timing_q[JMP_LO +: JMP_W]),
    .fall_edge, .sample_pt, .bit_end
  );

  cbt_sampler #(.NSAMP(NSAMP)) u_smp (
    .clk, .rst_n, .run, .tq_tick, .rxp,
    .vote_en(timing_q[VOTE_B]), .sample_pt, .rx_bit
  );

  AST_QUIET_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (!sample_stb && !bit_start_stb)); // R10
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start_stb)); // R4
endmodule

// File: tb/cbt_top_tb_top.sv
`timescale 1ns/1ps
module cbt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        mode_we = 1'b0, mode_hold_d = 1'b0, mode_rxinv_d = 1'b0;
  logic        bus_off = 1'b0, rx_raw = 1'b1;
  logic [15:0] timing_q;
  logic        hold_q, rxinv_q, rx_bit, sample_stb, bit_start_stb;
  int          n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  cbt_top dut_i (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .mode_we, .mode_hold_d, .mode_rxinv_d,
    .bus_off, .rx_raw, .timing_q, .hold_q, .rxinv_q, .rx_bit, .sample_stb,
    .bit_start_stb
  );

  // Timing settings the bench applies (prescale, pre, post, jump).
  int ps = 1, pre = 5, post = 3, jmp = 1;

  function automatic int bit_clks();
    return (ps + 1) * (1 + (pre + 1) + (post + 1));
  endfunction
  function automatic int pre_edge_len(input int k);
    int e = k + 1;
    if (e > jmp + 1) e = jmp + 1;
    return bit_clks() + e * (ps + 1);
  endfunction
  function automatic int post_edge_len(input int k);
    int full = post + 1;
    int rem = full - k;
    int nl;
    if (rem > jmp + 1) rem = jmp + 1;
    nl = full - rem;
    if (nl < k + 1) nl = k + 1;
    return bit_clks() - (full - nl) * (ps + 1);
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic h, input logic inv);
    @(negedge clk);
    mode_we = 1'b1; mode_hold_d = h; mode_rxinv_d = inv;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic count_strobes(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sample_stb || bit_start_stb) hits++;
    end
  endtask

  // Waits for a bit start, applies up to three line events at given
  // cycle offsets, returns bit length, sample offset and sampled bit.
  task automatic run_bit(input int t0, input logic v0, input int t1, input logic v1,
                         input int t2, input logic v2,
                         output int len, output int soff, output logic sbit);
    int g = 0;
    int n = 0;
    while (!bit_start_stb && g < 400) begin
      @(negedge clk);
      g++;
    end
    soff = -1; sbit = 1'bx;
    while (n < 400) begin
      @(negedge clk);
      n++;
      if (n == t0) rx_raw = v0;
      if (n == t1) rx_raw = v1;
      if (n == t2) rx_raw = v2;
      if (sample_stb) begin
        soff = n;
        sbit = rx_bit;
      end
      if (bit_start_stb) break;
    end
    len = n;
  endtask

  task automatic t_reset();
    int hits;
    check_eq("R1 hold flag", int'(hold_q), 1);
    check_eq("R1 timing word", int'(timing_q), 0);
    check_eq("R1 inversion flag", int'(rxinv_q), 0);
    count_strobes(30, hits);
    check_eq("R1 strobes after reset", hits, 0);
  endtask

  task automatic t_config();
    write_cfg(16'h3541);
    check_eq("R2 write in hold mode", int'(timing_q), 'h3541);
    set_mode(1'b0, 1'b0);
  endtask

  task automatic t_period();
    int len, soff; logic sb;
    run_bit(-1, 1'b0, -1, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R3 bit period", len, bit_clks());
    check_eq("R4 sample offset", soff, (ps + 1) * (pre + 2));
    check_eq("R5 plain level high", int'(sb), 1);
  endtask

  task automatic t_lock();
    int len, soff; logic sb;
    write_cfg(16'hFFFF);
    check_eq("R2 write ignored when running", int'(timing_q), 'h3541);
    run_bit(-1, 1'b0, -1, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R2 period unchanged", len, bit_clks());
    set_mode(1'b0, 1'b1);
    check_eq("R5 inversion locked when running", int'(rxinv_q), 0);
  endtask

  task automatic t_pre_resync();
    int len, soff; logic sb;
    run_bit(2, 1'b0, -1, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R7 edge pre quantum 0", len, pre_edge_len(0));
    run_bit(1, 1'b1, -1, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R9 rising edge ignored", len, bit_clks());
    run_bit(8, 1'b0, -1, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R7 edge pre quantum 3 clipped", len, pre_edge_len(3));
    run_bit(1, 1'b1, -1, 1'b0, -1, 1'b0, len, soff, sb);
    run_bit(2, 1'b0, 4, 1'b1, 6, 1'b0, len, soff, sb);
    check_eq("R9 second edge ignored", len, pre_edge_len(0));
    run_bit(1, 1'b1, -1, 1'b0, -1, 1'b0, len, soff, sb);
  endtask

  task automatic t_post_resync();
    int len, soff; logic sb;
    run_bit(16, 1'b0, -1, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R8 edge post quantum 1", len, post_edge_len(1));
    run_bit(1, 1'b1, -1, 1'b0, -1, 1'b0, len, soff, sb);
    run_bit(20, 1'b0, -1, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R8 edge last post quantum clamp", len, post_edge_len(3));
    run_bit(1, 1'b1, -1, 1'b0, -1, 1'b0, len, soff, sb);
  endtask

  task automatic t_polarity();
    int len, soff; logic sb;
    run_bit(1, 1'b0, -1, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R9 edge in sync ignored", len, bit_clks());
    check_eq("R5 plain level low", int'(sb), 0);
    set_mode(1'b1, 1'b0);
    set_mode(1'b1, 1'b1);
    check_eq("R5 inversion written in hold", int'(rxinv_q), 1);
    set_mode(1'b0, 1'b1);
    run_bit(-1, 1'b0, -1, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R5 inverted low line", int'(sb), 1);
    set_mode(1'b1, 1'b0);
    set_mode(1'b0, 1'b0);
  endtask

  task automatic t_vote();
    int len, soff; logic sb;
    set_mode(1'b1, 1'b0);
    write_cfg(16'hB541);
    set_mode(1'b0, 1'b0);
    run_bit(12, 1'b1, 14, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R6 vote rejects glitch", int'(sb), 0);
    set_mode(1'b1, 1'b0);
    write_cfg(16'h3541);
    set_mode(1'b0, 1'b0);
    run_bit(12, 1'b1, 14, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R6 single sample sees glitch", int'(sb), 1);
  endtask

  task automatic t_bus_off();
    int hits;
    int n = 0;
    @(negedge clk); bus_off = 1'b1;
    @(negedge clk); bus_off = 1'b0;
    check_eq("R10 bus-off sets hold", int'(hold_q), 1);
    count_strobes(40, hits);
    check_eq("R10 no strobes in hold", hits, 0);
    mode_we = 1'b1; mode_hold_d = 1'b0; mode_rxinv_d = 1'b0;
    while (n < 400) begin
      @(negedge clk);
      n++;
      if (n == 1) mode_we = 1'b0;
      if (bit_start_stb) break;
    end
    check_eq("R10 first bit start after release", n, bit_clks() + 1);
  endtask

  task automatic t_alt_timing();
    int len, soff; logic sb;
    set_mode(1'b1, 1'b0);
    write_cfg(16'h1203);
    ps = 3; pre = 2; post = 1; jmp = 0;
    set_mode(1'b0, 1'b0);
    run_bit(-1, 1'b0, -1, 1'b0, -1, 1'b0, len, soff, sb);
    check_eq("R3 period slow quantum", len, bit_clks());
    check_eq("R4 sample offset slow quantum", soff, (ps + 1) * (pre + 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_period();
    t_lock();
    t_pre_resync();
    t_post_resync();
    t_polarity();
    t_vote();
    t_bus_off();
    t_alt_timing();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule